// File: doc/BRIEF.md
# Divided-Clock Countdown Interrupt Timer

This block is the interrupt timer of a processor's local interrupt unit. The input clock first passes through a power-of-two prescaler, with the ratio taken from a divide register. The prescaled ticks then drive a 32-bit down-counter, which starts from a programmed initial count. A control register holds three things: the interrupt vector, a mask bit, and a bit that selects periodic or one-shot mode. When the counter expires, the block raises a one-cycle request that carries the vector, and it marks that request as edge-triggered.

Software sets up the control and divide registers and then writes the initial count. That write restarts both the prescaler and the counter. In periodic mode the counter reloads after it passes zero, so each period lasts initial+1 ticks. In one-shot mode the counter stops at zero after a single expiry. The current count is always visible on an output. The interrupt controller that latches the vector is outside this block.

Top module: `cdown_timer`

## Requirements
- R1: After reset the count output is 0, no request is raised, the control register is masked, and the divide shift is 0. While the mask stays set, loading a count produces no request.
- R2: A divide write forms v = {wdata[3], wdata[1], wdata[0]}. The shift is (v+1) mod 8, and one tick occurs every 2^shift clocks, so 0b111 divides by 1 and 0b000 divides by 2. Bit 2 is ignored.
- R3: An initial-count write shows its value on the count output one clock later and restarts the prescaler. After k further clocks the elapsed ticks equal k >> shift, and the count never steps by more than one per clock.
- R4: In one-shot mode (control bit 17 = 0) the count reads initial − ticks, stops at 0, and raises exactly one request on the tick after it reaches 0, which is tick initial+1.
- R5: In periodic mode (control bit 17 = 1) the count reads initial − (ticks mod (initial+1)). A request is raised on every tick that reloads the count from 0 back to the initial value.
- R6: An initial count of 0 produces no request in either mode, and the count reads 0.
- R7: While control bit 16 (mask) is 1, no request is raised but the count keeps running. A one-shot expiry that happens while masked is lost.
- R8: A request is a one-cycle pulse on irq_o. irq_vector_o carries control bits [7:0], and irq_level_o reads 0, meaning edge-triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Write strobe for the control register |
| div_we_i | input | 1 | Write strobe for the divide register |
| init_we_i | input | 1 | Write strobe for the initial count; restarts counting |
| wdata_i | input | 32 | Write data shared by all strobes |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vector_o | output | 8 | Vector carried with the request |
| irq_level_o | output | 1 | Trigger mode of the request, 0 = edge |

## Verification
A prescaler phase error shows up as a count that is off by one tick at the sample point. It appears within 2^shift clocks, so the bench samples at exact clock offsets for several divide encodings. A lost or stale armed state changes how many requests are seen: a one-shot request may be repeated, or one may be missing. This shows up one tick after the count reaches zero, so the bench counts requests across whole windows. A wrong reload value shows up on the very next tick after a wrap as an incorrect count.

// File: rtl/cdown_timer_pkg.sv
package cdown_timer_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } ctrl_t;

  // v = {b3,b1,b0}; shift = (v+1) mod 8
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] code);
    return SHIFT_W'({code[3], code[1:0]} + 3'd1);
  endfunction
endpackage

// File: rtl/cdown_prescaler.sv
module cdown_prescaler #(
  parameter int unsigned SHIFT_W = 3,
  localparam int unsigned PRE_W  = (1 << SHIFT_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = ~({PRE_W{1'b1}} << shift_i);
  // >= keeps the period bounded if the shift shrinks mid-count
  assign tick_o = !restart_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_o)    pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  p_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o || restart_i) |=> (pre_q == '0));
endmodule

// File: rtl/cdown_counter.sv
module cdown_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             mask_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vector_o
);
  logic [CNT_W-1:0] cur_q;
  logic             armed_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  logic             at_zero;
  logic             expire;

  assign at_zero = (cur_q == '0);
  assign expire  = tick_i && at_zero && !mask_i &&
                   (periodic_i ? (init_i != '0) : armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (load_i) begin
        cur_q   <= load_val_i;
        armed_q <= (load_val_i != '0);
      end else if (tick_i) begin
        if (!at_zero) begin
          cur_q <= cur_q - 1'b1;
        end else begin
          if (periodic_i) cur_q <= init_i;
          else            armed_q <= 1'b0;   // one-shot: expiry used up, even if masked
          irq_q <= expire;
          if (expire) vec_q <= vector_i;
        end
      end
    end
  end

  assign count_o  = cur_q;
  assign irq_o    = irq_q;
  assign vector_o = vec_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !at_zero) |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) - 1'b1));
  p_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !periodic_i && at_zero) |=> (cur_q == '0));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && $past(periodic_i)) |-> (cur_q == init_i));
  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdown_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             div_we_i,
  input  logic             init_we_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vector_o,
  output logic             irq_level_o
);
  ctrl_t              ctrl_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   init_q;
  logic               tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
      shift_q <= '0;
      init_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q.periodic <= wdata_i[PER_BIT];
        ctrl_q.mask     <= wdata_i[MASK_BIT];
        ctrl_q.vector   <= wdata_i[VEC_W-1:0];
      end
      if (div_we_i)  shift_q <= div_to_shift(wdata_i[3:0]);
      if (init_we_i) init_q  <= wdata_i[CNT_W-1:0];
    end
  end

  cdown_prescaler #(.SHIFT_W(SHIFT_W)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (init_we_i),
    .shift_i   (shift_q),
    .tick_o    (tick)
  );

  cdown_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_we_i),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .init_i     (init_q),
    .tick_i     (tick),
    .periodic_i (ctrl_q.periodic),
    .mask_i     (ctrl_q.mask),
    .vector_i   (ctrl_q.vector),
    .count_o    (count_o),
    .irq_o      (irq_o),
    .vector_o   (irq_vector_o)
  );

  assign irq_level_o = 1'b0;

  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(ctrl_q.mask));
  p_zero_init_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (init_q != '0));
endmodule

// File: tb/test_cdown_timer.sv
`timescale 1ns/1ps
module test_cdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, div_we = 1'b0, init_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] count;
  logic        irq, irq_level;
  logic [7:0]  irq_vec;

  int n_chk = 0, n_fail = 0, irq_seen = 0;
  logic [7:0] last_vec = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cdown_timer i_cdown_timer (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .div_we_i(div_we),
    .init_we_i(init_we), .wdata_i(wdata), .count_o(count), .irq_o(irq),
    .irq_vector_o(irq_vec), .irq_level_o(irq_level)
  );

  always @(negedge clk) if (irq) begin irq_seen++; last_vec = irq_vec; end

  typedef struct packed {
    logic [3:0]  div;
    logic        per;
    logic        msk;
    logic [31:0] init;
    logic [15:0] k;
    logic [31:0] exp_cnt;
    logic [7:0]  exp_irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{4'hB, 1'b0, 1'b0, 32'd10,  16'd4,   32'd6,  8'd0},  // R4 shift0 mid-count
    '{4'hB, 1'b0, 1'b0, 32'd10,  16'd15,  32'd0,  8'd1},  // R4 stick at 0, one irq
    '{4'h0, 1'b0, 1'b0, 32'd10,  16'd7,   32'd7,  8'd0},  // R2 code 000 -> /2
    '{4'h3, 1'b1, 1'b0, 32'd100, 16'd50,  32'd97, 8'd0},  // R2 /16
    '{4'hB, 1'b1, 1'b0, 32'd5,   16'd14,  32'd3,  8'd2},  // R5 two wraps
    '{4'h8, 1'b1, 1'b0, 32'd3,   16'd200, 32'd1,  8'd1},  // R5 /32
    '{4'h2, 1'b1, 1'b0, 32'd0,   16'd40,  32'd0,  8'd0},  // R6 periodic zero
    '{4'hF, 1'b0, 1'b0, 32'd0,   16'd10,  32'd0,  8'd0},  // R6 one-shot zero, R2 bit2 ignored
    '{4'hA, 1'b0, 1'b0, 32'd2,   16'd400, 32'd0,  8'd1},  // R2 /128
    '{4'hB, 1'b1, 1'b1, 32'd4,   16'd20,  32'd4,  8'd0}   // R7 masked, count runs
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    ctrl_we = (sel == 0); div_we = (sel == 1); init_we = (sel == 2);
    @(posedge clk); #1;
    ctrl_we = 0; div_we = 0; init_we = 0;
  endtask

  task automatic after(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk); #1;
  endtask

  function automatic logic [31:0] ctrl_word(input logic per, input logic msk, input logic [7:0] v);
    return {14'd0, per, msk, 8'd0, v};
  endfunction

  initial begin
    int base;
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 count", count, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // control still masked from reset: no request
    wr(1, 32'hB); wr(2, 32'd2); base = irq_seen;
    after(10);
    chk("R1 masked count", count, 0);
    chk("R1 masked irq", irq_seen - base, 0);

    for (int i = 0; i < NV; i++) begin
      wr(0, ctrl_word(TBL[i].per, TBL[i].msk, 8'h40 + 8'(i)));
      wr(1, {28'd0, TBL[i].div});
      wr(2, TBL[i].init);
      base = irq_seen;
      after(int'(TBL[i].k));
      chk($sformatf("R4/R5 count vec%0d", i), count, TBL[i].exp_cnt);
      chk($sformatf("R5/R7 irqs vec%0d", i), irq_seen - base, 32'(TBL[i].exp_irq));
      if (TBL[i].exp_irq != 0) chk($sformatf("R8 vector vec%0d", i), {24'd0, last_vec}, 32'h40 + i);
    end

    // R4/R8 exact pulse timing, shift 0
    wr(0, ctrl_word(1'b0, 1'b0, 8'h55)); wr(1, 32'hB); wr(2, 32'd3);
    chk("R3 load visible", count, 3);
    after(2);
    chk("R4 no irq before expiry", {31'd0, irq}, 0);
    after(0);
    repeat (1) @(posedge clk); @(negedge clk); #1;
    chk("R4 irq on tick init+1", {31'd0, irq}, 1);
    chk("R8 vector", {24'd0, irq_vec}, 32'h55);
    chk("R8 edge marker", {31'd0, irq_level}, 0);
    after(1);
    chk("R8 single cycle", {31'd0, irq}, 0);

    // R3 restart mid-count
    wr(0, ctrl_word(1'b1, 1'b0, 8'h21)); wr(2, 32'd20);
    after(7);
    chk("R3 running", count, 13);
    wr(2, 32'd9);
    chk("R3 reload", count, 9);

    // R5 reload value on wrap
    wr(2, 32'd2);
    after(3);
    chk("R5 wrap irq", {31'd0, irq}, 1);
    chk("R5 wrap reload", count, 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule